// File: doc/BRIEF.md
# Configurable Counter and Flag Field

This block is one field of a register file, meant to serve as either a performance counter or a set of sticky flags. A single data register of `W` bits is updated from three sources: a simple bus port that reads and writes the field, a group of hardware control inputs, and a monitored vector from the surrounding logic. Parameters fix how a bus write combines with the stored value, what a bus read does to it afterwards, and how the monitored vector is used.

The updates that arrive in one cycle are applied one after another, in a fixed order, before the edge that stores the result. The order is:

1. the hardware clear;
2. the bus write;
3. the read side effect;
4. hardware increment, then decrement;
5. hardware bit-set, then bit-clear, then bit-toggle;
6. the monitor step.

A synchronous hardware reset overrides all of them. Every step that moves the value up or down, or sets or clears bits, can report a wrap or a redundant bit operation. These reports are collected into four event pulses. The pulses are registered together with the data, so each one is high during the cycle that follows the update that caused it.

The block has no state machine. Its only states are the data register and the event register, and every cycle produces a fresh result from them.

Top module: `cf_field`

## Requirements
- R1: While `rst_n` is low, and in the cycle after `hw_rst` is sampled high, `field_q` equals the parameter `RESET_VAL` and all four event pulses are 0. `hw_rst` overrides every other input in the same cycle.
- R2: `hw_clr` sets the value to zero before any other step of the same cycle, so `hw_clr` together with `hw_inc` stores 1.
- R3: A bus write with `bus_wr_en` high combines `bus_wr_data` with the value according to `BUS_MODE`. `BW_WRITE` replaces the value. `BW_ACCUM` adds. `BW_SUB` subtracts. `BW_BSET`, `BW_BCLR` and `BW_BTGL` set, clear or toggle each bit written as 1. All arithmetic wraps modulo 2^W.
- R4: `bus_rd_data` always shows the stored value. When `bus_rd_en` is high, `RD_FX` applies one effect after the bus write step: `RF_CLEAR` stores zero, `RF_INC` adds one, `RF_DEC` subtracts one, and `RF_NONE` does nothing.
- R5: `hw_inc` adds one and `hw_dec` subtracts one, in that order, both wrapping. When both are high the value is unchanged.
- R6: The W-bit inputs `hw_bset`, `hw_bclr` and `hw_btgl` are applied in that order. They set, clear and then toggle each bit whose input bit is 1.
- R7: `ovf_o` is high in the cycle after any increasing step (bus accumulate, read increment, `hw_inc`, or monitor count) changes the MSB from 1 to 0.
- R8: `unf_o` is high in the cycle after any decreasing step (bus subtract, read decrement, or `hw_dec`) changes the MSB from 0 to 1.
- R9: `bit_ovf_o` is high in the cycle after a bit-set step (bus bit-set, `hw_bset`, or monitor sticky) targets a bit that is already 1. `bit_unf_o` is high in the cycle after a bit-clear step (bus bit-clear or `hw_bclr`) targets a bit that is already 0.
- R10: `MON_MODE` sets how `mon_vec` is used, as the last step. `MON_STATUS` loads `mon_vec` and overrides the earlier steps. `MON_STICKY` ORs `mon_vec` into the value. `MON_COUNT` adds the number of 1 bits in `mon_vec`. `MON_OFF` ignores it.
- R11: Under any mix of inputs in the same cycle, the stored value and the pulses follow the step order given above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_en | input | 1 | Bus write strobe |
| bus_wr_data | input | W | Bus write data |
| bus_rd_en | input | 1 | Bus read strobe (triggers the read side effect) |
| bus_rd_data | output | W | Stored value as seen by the bus |
| hw_rst | input | 1 | Synchronous reload of `RESET_VAL` |
| hw_clr | input | 1 | Zero the value before the other steps |
| hw_inc | input | 1 | Add one |
| hw_dec | input | 1 | Subtract one |
| hw_bset | input | W | Per-bit set |
| hw_bclr | input | W | Per-bit clear |
| hw_btgl | input | W | Per-bit toggle |
| mon_vec | input | W | Monitored status or event vector |
| field_q | output | W | Stored value for the hardware side |
| ovf_o | output | 1 | Counter wrap upward, registered |
| unf_o | output | 1 | Counter wrap downward, registered |
| bit_ovf_o | output | 1 | Set of an already-set bit, registered |
| bit_unf_o | output | 1 | Clear of an already-clear bit, registered |

## Verification
The step-size assertions assume that a cycle is otherwise idle. The clear check assumes that no bus, bit or monitor activity is present. The single-step increment check assumes that no other update is present and that the monitor is either off or seeing an all-zero event vector.

The cause assertions assume that every pulse follows a cycle in which a qualifying source was active. Every input is therefore held at zero while `rst_n` is low.

The directed phases drive one kind of update at a time, so the idle assumptions hold. The random phase then mixes all sources freely, and there the step order is checked by the bench model, not by the step assertions.

// File: rtl/cf_pkg.sv
package cf_pkg;

    // How a bus write combines with the stored value
    typedef enum logic [2:0] {
        BW_OFF,
        BW_WRITE,
        BW_ACCUM,
        BW_SUB,
        BW_BSET,
        BW_BCLR,
        BW_BTGL
    } bus_mode_e;

    // Side effect applied when the bus reads the field
    typedef enum logic [1:0] {
        RF_NONE,
        RF_CLEAR,
        RF_INC,
        RF_DEC
    } rd_fx_e;

    // Use of the monitored vector
    typedef enum logic [1:0] {
        MON_OFF,
        MON_STATUS,
        MON_STICKY,
        MON_COUNT
    } mon_mode_e;

    // Event report from one update stage
    typedef struct packed {
        logic ovf;
        logic unf;
        logic bovf;
        logic bunf;
    } evt_t;

    localparam evt_t EVT_NONE = '0;

endpackage

// File: rtl/cf_bus_stage.sv
module cf_bus_stage #(
    parameter int                W     = 8,
    parameter cf_pkg::bus_mode_e MODE  = cf_pkg::BW_ACCUM,
    parameter cf_pkg::rd_fx_e    RD_FX = cf_pkg::RF_NONE
) (
    input  logic [W-1:0]  v_in,
    input  logic          wr_en,
    input  logic [W-1:0]  wr_data,
    input  logic          rd_en,
    output logic [W-1:0]  v_out,
    output cf_pkg::evt_t  evt
);
    localparam int MSB = W - 1;

    logic [W-1:0] wr_res;
    logic [W-1:0] wr_tmp;
    logic [W-1:0] rd_tmp;
    cf_pkg::evt_t wr_evt;
    cf_pkg::evt_t rd_evt;

    // Write step: combine the write data according to MODE
    always_comb begin
        wr_res = v_in;
        wr_tmp = '0;
        wr_evt = cf_pkg::EVT_NONE;
        if (wr_en) begin
            case (MODE)
                cf_pkg::BW_WRITE: begin
                    wr_res = wr_data;
                end
                cf_pkg::BW_ACCUM: begin
                    wr_tmp     = v_in + wr_data;
                    wr_res     = wr_tmp;
                    wr_evt.ovf = v_in[MSB] & ~wr_tmp[MSB];
                end
                cf_pkg::BW_SUB: begin
                    wr_tmp     = v_in - wr_data;
                    wr_res     = wr_tmp;
                    wr_evt.unf = ~v_in[MSB] & wr_tmp[MSB];
                end
                cf_pkg::BW_BSET: begin
                    wr_res      = v_in | wr_data;
                    wr_evt.bovf = |(v_in & wr_data);
                end
                cf_pkg::BW_BCLR: begin
                    wr_res      = v_in & ~wr_data;
                    wr_evt.bunf = |(~v_in & wr_data);
                end
                cf_pkg::BW_BTGL: begin
                    wr_res = v_in ^ wr_data;
                end
                default: begin
                    wr_res = v_in;
                end
            endcase
        end
    end

    // Read side effect, applied after the write step
    always_comb begin
        v_out  = wr_res;
        rd_tmp = '0;
        rd_evt = cf_pkg::EVT_NONE;
        if (rd_en) begin
            case (RD_FX)
                cf_pkg::RF_CLEAR: begin
                    v_out = '0;
                end
                cf_pkg::RF_INC: begin
                    rd_tmp     = wr_res + W'(1);
                    v_out      = rd_tmp;
                    rd_evt.ovf = wr_res[MSB] & ~rd_tmp[MSB];
                end
                cf_pkg::RF_DEC: begin
                    rd_tmp     = wr_res - W'(1);
                    v_out      = rd_tmp;
                    rd_evt.unf = ~wr_res[MSB] & rd_tmp[MSB];
                end
                default: begin
                    v_out = wr_res;
                end
            endcase
        end
    end

    assign evt = cf_pkg::evt_t'(wr_evt | rd_evt);

endmodule

// File: rtl/cf_hw_stage.sv
module cf_hw_stage #(
    parameter int W = 8
) (
    input  logic [W-1:0]  v_in,
    input  logic          inc,
    input  logic          dec,
    input  logic [W-1:0]  bset,
    input  logic [W-1:0]  bclr,
    input  logic [W-1:0]  btgl,
    output logic [W-1:0]  v_out,
    output cf_pkg::evt_t  evt
);
    localparam int MSB = W - 1;

    logic [W-1:0] a_inc;
    logic [W-1:0] a_dec;
    logic [W-1:0] a_set;
    logic [W-1:0] a_clr;

    // Increment, decrement, set, clear, toggle, each on the previous result
    always_comb begin
        a_inc    = v_in + W'(inc);
        a_dec    = a_inc - W'(dec);
        a_set    = a_dec | bset;
        a_clr    = a_set & ~bclr;
        v_out    = a_clr ^ btgl;
        evt      = cf_pkg::EVT_NONE;
        evt.ovf  = inc & v_in[MSB] & ~a_inc[MSB];
        evt.unf  = dec & ~a_inc[MSB] & a_dec[MSB];
        evt.bovf = |(bset & a_dec);
        evt.bunf = |(bclr & ~a_set);
    end

endmodule

// File: rtl/cf_mon_stage.sv
module cf_mon_stage #(
    parameter int                W    = 8,
    parameter cf_pkg::mon_mode_e MODE = cf_pkg::MON_OFF
) (
    input  logic [W-1:0]  v_in,
    input  logic [W-1:0]  mon_vec,
    output logic [W-1:0]  v_out,
    output cf_pkg::evt_t  evt
);
    localparam int MSB = W - 1;
    localparam int CW  = $clog2(W + 1);

    function automatic logic [CW-1:0] ones_in(input logic [W-1:0] vec);
        logic [CW-1:0] n;
        n = '0;
        for (int b = 0; b < W; b++) begin
            n = n + CW'(vec[b]);
        end
        return n;
    endfunction

    logic [CW-1:0] n_events;
    logic [W-1:0]  cnt_sum;

    assign n_events = ones_in(mon_vec);
    assign cnt_sum  = v_in + W'(n_events);

    always_comb begin
        v_out = v_in;
        evt   = cf_pkg::EVT_NONE;
        case (MODE)
            cf_pkg::MON_STATUS: begin
                v_out = mon_vec;
            end
            cf_pkg::MON_STICKY: begin
                v_out    = v_in | mon_vec;
                evt.bovf = |(v_in & mon_vec);
            end
            cf_pkg::MON_COUNT: begin
                v_out   = cnt_sum;
                evt.ovf = v_in[MSB] & ~cnt_sum[MSB];
            end
            default: begin
                v_out = v_in;
            end
        endcase
    end

endmodule

// File: rtl/cf_field.sv
module cf_field #(
    parameter int                W         = 8,
    parameter cf_pkg::bus_mode_e BUS_MODE  = cf_pkg::BW_ACCUM,
    parameter cf_pkg::rd_fx_e    RD_FX     = cf_pkg::RF_INC,
    parameter cf_pkg::mon_mode_e MON_MODE  = cf_pkg::MON_COUNT,
    parameter logic [W-1:0]      RESET_VAL = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr_en,
    input  logic [W-1:0]  bus_wr_data,
    input  logic          bus_rd_en,
    output logic [W-1:0]  bus_rd_data,
    input  logic          hw_rst,
    input  logic          hw_clr,
    input  logic          hw_inc,
    input  logic          hw_dec,
    input  logic [W-1:0]  hw_bset,
    input  logic [W-1:0]  hw_bclr,
    input  logic [W-1:0]  hw_btgl,
    input  logic [W-1:0]  mon_vec,
    output logic [W-1:0]  field_q,
    output logic          ovf_o,
    output logic          unf_o,
    output logic          bit_ovf_o,
    output logic          bit_unf_o
);
    logic [W-1:0] data_q;
    cf_pkg::evt_t evt_q;

    logic [W-1:0] v_clr;
    logic [W-1:0] v_bus;
    logic [W-1:0] v_hw;
    logic [W-1:0] v_mon;
    cf_pkg::evt_t e_bus;
    cf_pkg::evt_t e_hw;
    cf_pkg::evt_t e_mon;
    cf_pkg::evt_t e_all;

    // Step 1: clear comes first
    assign v_clr = hw_clr ? '0 : data_q;

    // Step 2: bus write and read side effect
    cf_bus_stage #(
        .W     (W),
        .MODE  (BUS_MODE),
        .RD_FX (RD_FX)
    ) u_bus (
        .v_in    (v_clr),
        .wr_en   (bus_wr_en),
        .wr_data (bus_wr_data),
        .rd_en   (bus_rd_en),
        .v_out   (v_bus),
        .evt     (e_bus)
    );

    // Step 3: hardware arithmetic and bit operations
    cf_hw_stage #(
        .W (W)
    ) u_hw (
        .v_in  (v_bus),
        .inc   (hw_inc),
        .dec   (hw_dec),
        .bset  (hw_bset),
        .bclr  (hw_bclr),
        .btgl  (hw_btgl),
        .v_out (v_hw),
        .evt   (e_hw)
    );

    // Step 4: monitored vector
    cf_mon_stage #(
        .W    (W),
        .MODE (MON_MODE)
    ) u_mon (
        .v_in    (v_hw),
        .mon_vec (mon_vec),
        .v_out   (v_mon),
        .evt     (e_mon)
    );

    assign e_all = cf_pkg::evt_t'(e_bus | e_hw | e_mon);

    // Data and event registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= RESET_VAL;
            evt_q  <= cf_pkg::EVT_NONE;
        end else if (hw_rst) begin
            data_q <= RESET_VAL;
            evt_q  <= cf_pkg::EVT_NONE;
        end else begin
            data_q <= v_mon;
            evt_q  <= e_all;
        end
    end

    assign bus_rd_data = data_q;
    assign field_q     = data_q;
    assign ovf_o       = evt_q.ovf;
    assign unf_o       = evt_q.unf;
    assign bit_ovf_o   = evt_q.bovf;
    assign bit_unf_o   = evt_q.bunf;

    // Qualifiers used by the assertions below
    logic no_bus;
    logic no_bits;
    logic mon_idle;
    assign no_bus   = !bus_wr_en && !bus_rd_en;
    assign no_bits  = (hw_bset == '0) && (hw_bclr == '0) && (hw_btgl == '0);
    assign mon_idle = (MON_MODE == cf_pkg::MON_OFF) ||
                      ((MON_MODE != cf_pkg::MON_STATUS) && (mon_vec == '0));

    AST_RESET_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        hw_rst |=> (field_q == RESET_VAL) && !ovf_o && !unf_o && !bit_ovf_o && !bit_unf_o); // R1

    AST_CLEAR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (!hw_rst && hw_clr && !hw_inc && !hw_dec && no_bus && no_bits && mon_idle)
        |=> (field_q == '0)); // R2

    AST_INC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!hw_rst && !hw_clr && hw_inc && !hw_dec && no_bus && no_bits && mon_idle)
        |=> (field_q == $past(field_q) + W'(1))); // R5

    AST_OVF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |-> $past(hw_inc || (bus_wr_en && BUS_MODE == cf_pkg::BW_ACCUM) ||
                        (bus_rd_en && RD_FX == cf_pkg::RF_INC) ||
                        (MON_MODE == cf_pkg::MON_COUNT && mon_vec != '0))); // R7

    AST_UNF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        unf_o |-> $past(hw_dec || (bus_wr_en && BUS_MODE == cf_pkg::BW_SUB) ||
                        (bus_rd_en && RD_FX == cf_pkg::RF_DEC))); // R8

    AST_BOVF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        bit_ovf_o |-> $past((hw_bset != '0) ||
                            (bus_wr_en && BUS_MODE == cf_pkg::BW_BSET && bus_wr_data != '0) ||
                            (MON_MODE == cf_pkg::MON_STICKY && mon_vec != '0))); // R9

    AST_BUNF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        bit_unf_o |-> $past((hw_bclr != '0) ||
                            (bus_wr_en && BUS_MODE == cf_pkg::BW_BCLR && bus_wr_data != '0))); // R9

endmodule

// File: tb/cf_field_tb.sv
`timescale 1ns/1ps
module cf_field_tb;
    import cf_pkg::*;

    localparam int           W  = 8;
    localparam int           N  = 6;
    localparam logic [W-1:0] RV = 8'h7E;

    // Per-instance configuration
    function automatic bus_mode_e bm_of(input int i);
        case (i)
            0: return BW_ACCUM;
            1: return BW_BSET;
            2: return BW_SUB;
            3: return BW_BCLR;
            4: return BW_BTGL;
            default: return BW_WRITE;
        endcase
    endfunction

    function automatic rd_fx_e rf_of(input int i);
        case (i)
            0: return RF_INC;
            1: return RF_CLEAR;
            2: return RF_DEC;
            5: return RF_INC;
            default: return RF_NONE;
        endcase
    endfunction

    function automatic mon_mode_e mm_of(input int i);
        case (i)
            0: return MON_COUNT;
            1: return MON_STICKY;
            3: return MON_STATUS;
            default: return MON_OFF;
        endcase
    endfunction

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic         wen, ren, hrst, hclr, hinc, hdec;
    logic [W-1:0] wd, bset, bclr, btgl, mv;

    logic [N-1:0][W-1:0] dq;
    logic [N-1:0][W-1:0] rdq;
    logic [N-1:0][3:0]   fl;

    for (genvar g = 0; g < N; g++) begin : g_dut
        cf_field #(
            .W         (W),
            .BUS_MODE  (bm_of(g)),
            .RD_FX     (rf_of(g)),
            .MON_MODE  (mm_of(g)),
            .RESET_VAL (RV)
        ) u_dut (
            .clk         (clk),
            .rst_n       (rst_n),
            .bus_wr_en   (wen),
            .bus_wr_data (wd),
            .bus_rd_en   (ren),
            .bus_rd_data (rdq[g]),
            .hw_rst      (hrst),
            .hw_clr      (hclr),
            .hw_inc      (hinc),
            .hw_dec      (hdec),
            .hw_bset     (bset),
            .hw_bclr     (bclr),
            .hw_btgl     (btgl),
            .mon_vec     (mv),
            .field_q     (dq[g]),
            .ovf_o       (fl[g][3]),
            .unf_o       (fl[g][2]),
            .bit_ovf_o   (fl[g][1]),
            .bit_unf_o   (fl[g][0])
        );
    end

    int checks = 0;
    int errors = 0;
    logic [W-1:0] exp_d [N];

    // Behavioural next-value model; flags packed as {ovf, unf, bovf, bunf}
    function automatic void model(input int i, input logic [W-1:0] cur,
                                  output logic [W-1:0] nxt, output logic [3:0] nf);
        logic [W-1:0] v, t;
        logic o, u, bo, bu;
        o = 0; u = 0; bo = 0; bu = 0;
        if (hrst) begin
            nxt = RV;
            nf  = 4'b0;
            return;
        end
        v = cur;
        if (hclr) v = '0;
        if (wen) begin
            case (bm_of(i))
                BW_WRITE: v = wd;
                BW_ACCUM: begin t = v + wd; if (v[7] && !t[7]) o = 1; v = t; end
                BW_SUB:   begin t = v - wd; if (!v[7] && t[7]) u = 1; v = t; end
                BW_BSET:  begin if ((wd & v) != 0) bo = 1; v = v | wd; end
                BW_BCLR:  begin if ((wd & ~v) != 0) bu = 1; v = v & ~wd; end
                BW_BTGL:  v = v ^ wd;
                default:  ;
            endcase
        end
        if (ren) begin
            case (rf_of(i))
                RF_CLEAR: v = '0;
                RF_INC:   begin t = v + 8'd1; if (v[7] && !t[7]) o = 1; v = t; end
                RF_DEC:   begin t = v - 8'd1; if (!v[7] && t[7]) u = 1; v = t; end
                default:  ;
            endcase
        end
        if (hinc) begin t = v + 8'd1; if (v[7] && !t[7]) o = 1; v = t; end
        if (hdec) begin t = v - 8'd1; if (!v[7] && t[7]) u = 1; v = t; end
        if ((bset & v) != 0) bo = 1;
        v = v | bset;
        if ((bclr & ~v) != 0) bu = 1;
        v = v & ~bclr;
        v = v ^ btgl;
        case (mm_of(i))
            MON_STATUS: v = mv;
            MON_STICKY: begin if ((mv & v) != 0) bo = 1; v = v | mv; end
            MON_COUNT:  begin t = v + W'($countones(mv)); if (v[7] && !t[7]) o = 1; v = t; end
            default: ;
        endcase
        nxt = v;
        nf  = {o, u, bo, bu};
    endfunction

    task automatic chk(input string tag, input int i, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s inst %0d %s actual %h expected %h", tag, i, what, act, exp);
        end
    endtask

    task automatic idle();
        wen = 0; ren = 0; hrst = 0; hclr = 0; hinc = 0; hdec = 0;
        wd = '0; bset = '0; bclr = '0; btgl = '0; mv = '0;
    endtask

    // One clock: check the read port, predict, clock, compare
    task automatic step(input string tag);
        logic [W-1:0] nv [N];
        logic [3:0]   nf [N];
        for (int i = 0; i < N; i++) begin
            chk("R4", i, "bus_rd_data", rdq[i], exp_d[i]);
            model(i, exp_d[i], nv[i], nf[i]);
        end
        @(posedge clk);
        #1;
        for (int i = 0; i < N; i++) begin
            chk(tag, i, "field_q", dq[i], nv[i]);
            chk(tag, i, "events", {4'b0, fl[i]}, {4'b0, nf[i]});
            exp_d[i] = nv[i];
        end
        idle();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        $display("FAIL R11 watchdog expired actual running expected finished");
        checks++;
        errors++;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        idle();
        rst_n = 0;
        repeat (3) @(posedge clk);
        #1;
        for (int i = 0; i < N; i++) begin
            chk("R1", i, "reset value", dq[i], RV);
            chk("R1", i, "reset events", {4'b0, fl[i]}, 8'h00);
            exp_d[i] = RV;
        end
        rst_n = 1;

        // R3: bus writes in every mode
        wen = 1; wd = 8'h90; step("R3");
        wen = 1; wd = 8'h33; step("R3");
        wen = 1; wd = 8'hFF; step("R3");
        // R4: read side effects
        ren = 1; step("R4");
        ren = 1; step("R4");
        // R2: clear before increment
        hclr = 1; hinc = 1; step("R2");
        hclr = 1; step("R2");
        // R5: increment, decrement, both
        hinc = 1; step("R5");
        hdec = 1; step("R5");
        hdec = 1; step("R5");
        hinc = 1; hdec = 1; step("R5");
        // R6: hardware bit operations
        bset = 8'hF0; step("R6");
        bclr = 8'h30; step("R6");
        btgl = 8'h0F; step("R6");
        bset = 8'h03; bclr = 8'h01; btgl = 8'h81; step("R6");
        // R7: wraps upward from all-ones
        bset = 8'hFF; step("R7");
        hinc = 1; step("R7");
        bset = 8'hFF; step("R7");
        wen = 1; wd = 8'h01; step("R7");
        bset = 8'hFF; step("R7");
        ren = 1; step("R7");
        // R8: wraps downward from zero
        hclr = 1; step("R8");
        hdec = 1; step("R8");
        hclr = 1; step("R8");
        wen = 1; wd = 8'h01; step("R8");
        hclr = 1; ren = 1; step("R8");
        // R9: redundant bit operations
        bset = 8'h0F; step("R9");
        bset = 8'h01; step("R9");
        bclr = 8'h0F; step("R9");
        bclr = 8'h02; step("R9");
        wen = 1; wd = 8'h01; step("R9");
        // R10: monitor vector
        mv = 8'h0C; step("R10");
        mv = 8'h0C; step("R10");
        mv = 8'hFF; step("R10");
        mv = 8'h00; step("R10");
        // R1: synchronous reset wins over everything
        wen = 1; ren = 1; hclr = 1; hinc = 1; hdec = 1;
        wd = 8'hFF; bset = 8'hFF; bclr = 8'h0F; btgl = 8'h55; mv = 8'hFF;
        hrst = 1; step("R1");
        // R11: mixed random traffic
        for (int k = 0; k < 3000; k++) begin
            wen  = ($urandom_range(0, 2) == 0);
            ren  = ($urandom_range(0, 2) == 0);
            hclr = ($urandom_range(0, 15) == 0);
            hrst = ($urandom_range(0, 63) == 0);
            hinc = ($urandom_range(0, 1) == 1);
            hdec = ($urandom_range(0, 2) == 0);
            wd   = W'($urandom);
            bset = ($urandom_range(0, 3) == 0) ? W'($urandom) : '0;
            bclr = ($urandom_range(0, 3) == 0) ? W'($urandom) : '0;
            btgl = ($urandom_range(0, 3) == 0) ? W'($urandom) : '0;
            mv   = ($urandom_range(0, 2) == 0) ? W'($urandom) : '0;
            step("R11");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule